// File: doc/BRIEF.md
# Locked Node Current Accumulator

This block builds a node-indexed current vector out of many small signed contributions. Several producer ports, one per group, each present a node index and a value with a valid/ready handshake. Each accepted contribution is applied as a read, an add and a write-back to that group's own partial vector. A single shared adder pipeline with a configurable latency serves all ports. Each entry in flight through the adder is locked. A port whose target entry is locked is held off through its own ready signal, while ports aiming at other entries keep moving.

Each group marks its final contribution with a last flag. A group may finish at any time, and groups that finish early do not wait for the others. When every group has finished and the adder pipeline is empty, a merge phase starts. The merge reuses the same locked read-add-write path to add the per-group partial vectors, entry by entry, into a final vector. When the merge has drained, done is raised and the final vector can be read by node index. A clear command zeroes every vector and starts a new step.

Top module: `node_accum`

## Requirements
- R1: After reset or after a clear, every entry of the final vector reads as zero and done is low.
- R2: The contributions a group makes to one node are all added together in its partial vector. Arithmetic is two's complement with DW bits and wraps.
- R3: A port sending contributions to distinct nodes is accepted on every consecutive clock edge.
- R4: A contribution to an entry whose addition is still in flight is held off until the write-back completes. If one port sends two back-to-back contributions to the same node, the second is accepted exactly ADD_LAT+1 edges after the first, and neither is lost.
- R5: A port stalled on a locked entry does not stall another port whose target entry is free. The free port is accepted in the stalled cycles.
- R6: When several ports can be accepted in the same cycle, only the port with the lowest index is accepted.
- R7: done stays low until every group has delivered its contribution flagged last, however late that is, and until no addition remains in flight.
- R8: Once done is high, reading node n on rd_node returns the sum over all groups of their contributions to node n. done then stays high until a clear.
- R9: A port that has already delivered its last contribution, or that presents one while done is high, never sees ready. Its data has no effect on the final vector.
- R10: A clear ends the current step. The next step's results depend only on that step's contributions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Zero all vectors and start a new step |
| in_vld | input | M | Per-port contribution valid |
| in_node | input | M x NW | Per-port target node index |
| in_val | input | M x DW | Per-port signed contribution |
| in_last | input | M | Marks the group's final contribution |
| in_rdy | output | M | Per-port acceptance, high in the accept cycle |
| rd_node | input | NW | Node index to read from the final vector |
| rd_val | output | DW | Final vector entry at rd_node |
| done | output | 1 | Merge complete, final vector valid |

## Verification
The bench targets back-to-back hits on one node. A design that reads an entry before the earlier write-back lands would drop a contribution and leave a wrong sum, and one that unlocks too late or too early would show a different acceptance gap. It runs a port into a locked entry while another port targets a free entry. A global stall would delay the free port. It checks the priority order at the first contended cycle. It holds one group back for many cycles: a done raised on the early groups alone would show up before that group sends. It also drives requests after a port's last item and after done, where a leaking ready would change the final vector, and it repeats a step after a clear to catch state carried over.

// File: rtl/node_accum_pkg.sv
package node_accum_pkg;
    typedef enum logic [1:0] {
        PH_GROUP = 2'd0,
        PH_MERGE = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;
endpackage

// File: rtl/node_arb.sv
module node_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/accum_pipe.sv
module accum_pipe #(
    parameter int AW  = 5,
    parameter int DW  = 16,
    parameter int LAT = 2,
    parameter int NQ  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   in_vld,
    input  logic [AW-1:0]          in_addr,
    input  logic [DW-1:0]          in_sum,
    input  logic [NQ-1:0][AW-1:0]  q_addr,
    output logic [NQ-1:0]          q_busy,
    output logic                   wb_vld,
    output logic [AW-1:0]          wb_addr,
    output logic [DW-1:0]          wb_sum,
    output logic                   busy
);
    logic [LAT-1:0]         v_d, v_q;
    logic [LAT-1:0][AW-1:0] a_d, a_q;
    logic [LAT-1:0][DW-1:0] s_d, s_q;

    always_comb begin
        v_d[0] = in_vld & ~flush;
        a_d[0] = in_addr;
        s_d[0] = in_sum;
        for (int i = 1; i < LAT; i++) begin
            v_d[i] = v_q[i-1] & ~flush;
            a_d[i] = a_q[i-1];
            s_d[i] = s_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
            a_q <= '0;
            s_q <= '0;
        end else begin
            v_q <= v_d;
            a_q <= a_d;
            s_q <= s_d;
        end
    end

    for (genvar q = 0; q < NQ; q++) begin : g_lock
        always_comb begin
            q_busy[q] = 1'b0;
            for (int i = 0; i < LAT; i++)
                if (v_q[i] && a_q[i] == q_addr[q]) q_busy[q] = 1'b1;
        end
    end

    assign wb_vld  = v_q[LAT-1];
    assign wb_addr = a_q[LAT-1];
    assign wb_sum  = s_q[LAT-1];
    assign busy    = |v_q;

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !busy) else $error("flush left work in flight"); // R10
endmodule

// File: rtl/node_accum.sv
module node_accum
    import node_accum_pkg::*;
#(
    parameter int M       = 3,
    parameter int NODES   = 8,
    parameter int DW      = 16,
    parameter int ADD_LAT = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [M-1:0]          in_vld,
    input  logic [M-1:0][$clog2(NODES)-1:0] in_node,
    input  logic [M-1:0][DW-1:0]  in_val,
    input  logic [M-1:0]          in_last,
    output logic [M-1:0]          in_rdy,
    input  logic [$clog2(NODES)-1:0] rd_node,
    output logic [DW-1:0]         rd_val,
    output logic                  done
);
    localparam int NW    = $clog2(NODES);
    localparam int BW    = $clog2(M + 1);
    localparam int AW    = BW + NW;
    localparam int DEPTH = (M + 1) << NW;
    localparam int NQ    = M + 1;

    typedef struct packed {
        phase_e         ph;
        logic [M-1:0]   fin;
        logic [BW-1:0]  mg;
        logic [NW-1:0]  mn;
        logic           mdone;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    logic [NQ-1:0][AW-1:0] q_addr;
    logic [NQ-1:0]         q_busy;
    logic [M-1:0]          ok, gnt;
    logic                  iss_vld, wb_vld, pipe_busy;
    logic [AW-1:0]         iss_addr, wb_addr;
    logic [DW-1:0]         iss_sum, wb_sum;

    for (genvar g = 0; g < M; g++) begin : g_port
        assign q_addr[g] = {BW'(g), in_node[g]};
        assign ok[g] = in_vld[g] & ~q_busy[g] & ~c_q.fin[g] &
                       (c_q.ph == PH_GROUP) & ~clr;
    end
    assign q_addr[M] = {BW'(M), c_q.mn};

    node_arb #(.N(M)) u_arb (.req(ok), .gnt(gnt));
    assign in_rdy = gnt;

    accum_pipe #(.AW(AW), .DW(DW), .LAT(ADD_LAT), .NQ(NQ)) u_pipe (
        .clk(clk), .rst_n(rst_n), .flush(clr),
        .in_vld(iss_vld), .in_addr(iss_addr), .in_sum(iss_sum),
        .q_addr(q_addr), .q_busy(q_busy),
        .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_sum(wb_sum),
        .busy(pipe_busy)
    );

    always_comb begin
        c_d      = c_q;
        mem_d    = mem_q;
        iss_vld  = 1'b0;
        iss_addr = '0;
        iss_sum  = '0;
        for (int g = 0; g < M; g++) begin
            if (gnt[g]) begin
                iss_vld  = 1'b1;
                iss_addr = {BW'(g), in_node[g]};
                iss_sum  = mem_q[{BW'(g), in_node[g]}] + in_val[g];
            end
        end
        c_d.fin = c_q.fin | (gnt & in_last);
        case (c_q.ph)
            PH_GROUP: if (&c_q.fin && !pipe_busy) c_d.ph = PH_MERGE;
            PH_MERGE: begin
                if (!c_q.mdone) begin
                    if (!q_busy[M]) begin
                        iss_vld  = 1'b1;
                        iss_addr = {BW'(M), c_q.mn};
                        iss_sum  = mem_q[{BW'(M), c_q.mn}] + mem_q[{c_q.mg, c_q.mn}];
                        if (c_q.mn == NW'(NODES - 1)) begin
                            c_d.mn = '0;
                            if (c_q.mg == BW'(M - 1)) c_d.mdone = 1'b1;
                            else                      c_d.mg = c_q.mg + 1'b1;
                        end else begin
                            c_d.mn = c_q.mn + 1'b1;
                        end
                    end
                end else if (!pipe_busy) begin
                    c_d.ph = PH_DONE;
                end
            end
            default: ;
        endcase
        if (wb_vld) mem_d[wb_addr] = wb_sum;
        if (clr) begin
            c_d     = '0;
            iss_vld = 1'b0;
            for (int i = 0; i < DEPTH; i++) mem_d[i] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            c_q <= c_d;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_val = mem_q[{BW'(M), rd_node}];
    assign done   = (c_q.ph == PH_DONE);

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_rdy)) else $error("two ports accepted"); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pipe_busy) else $error("done with work in flight"); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !clr |=> done) else $error("done dropped"); // R8
    AST_CLR_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !done) else $error("done survived clear"); // R10
    for (genvar g = 0; g < M; g++) begin : g_chk
        AST_GRANT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            in_rdy[g] |-> !q_busy[g]) else $error("locked entry granted"); // R4
        AST_RDY_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
            in_rdy[g] |-> in_vld[g]) else $error("ready without valid"); // R5
        AST_NO_RDY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
            c_q.fin[g] || done |-> !in_rdy[g]) else $error("ready after last"); // R9
    end
endmodule

// File: tb/node_accum_bench.sv
module node_accum_bench;
    localparam int M = 3, NODES = 8, DW = 16, LAT = 2, NW = 3;

    logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
    logic [M-1:0] in_vld = '0, in_last = '0, in_rdy;
    logic [M-1:0][NW-1:0] in_node = '0;
    logic [M-1:0][DW-1:0] in_val = '0;
    logic [NW-1:0] rd_node = '0;
    logic [DW-1:0] rd_val;
    logic done;

    node_accum #(.M(M), .NODES(NODES), .DW(DW), .ADD_LAT(LAT)) u_node_accum (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_node(in_node),
        .in_val(in_val), .in_last(in_last), .in_rdy(in_rdy), .rd_node(rd_node),
        .rd_val(rd_val), .done(done));

    always #5 clk = ~clk;

    int cyc = 0, checks = 0, errors = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int src_node [M][16], src_val [M][16], src_len [M], src_dly [M], acc_cyc [M][16];
    int exp_q [$];

    task automatic chk(input bit cond, input string req, input int act, input int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic plan_expect();
        int e [NODES];
        for (int n = 0; n < NODES; n++) e[n] = 0;
        for (int g = 0; g < M; g++)
            for (int k = 0; k < src_len[g]; k++) e[src_node[g][k]] += src_val[g][k];
        for (int n = 0; n < NODES; n++) exp_q.push_back(e[n]);
    endtask

    task automatic push_zero();
        for (int n = 0; n < NODES; n++) exp_q.push_back(0);
    endtask

    // monitor: pops expected entries and compares them with the read port
    task automatic check_vec(input string req);
        for (int n = 0; n < NODES; n++) begin
            int e;
            @(negedge clk);
            rd_node = NW'(n);
            #1;
            e = exp_q.pop_front();
            chk(rd_val === DW'(e), req, $signed(rd_val), e);
        end
    endtask

    task automatic drive_grp(input int g);
        repeat (src_dly[g]) @(negedge clk);
        for (int k = 0; k < src_len[g]; k++) begin
            bit got = 0;
            in_vld[g]  = 1'b1;
            in_node[g] = NW'(src_node[g][k]);
            in_val[g]  = DW'(src_val[g][k]);
            in_last[g] = (k == src_len[g] - 1);
            while (!got) begin
                #1;
                if (in_rdy[g]) begin
                    got = 1;
                    acc_cyc[g][k] = cyc;
                end
                @(negedge clk);
            end
        end
        in_vld[g]  = 1'b0;
        in_last[g] = 1'b0;
    endtask

    task automatic clear_step();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic load_basic();
        src_len = '{8, 2, 1};
        src_dly = '{0, 0, 0};
        for (int k = 0; k < 8; k++) begin
            src_node[0][k] = k;
            src_val[0][k]  = 10 + k;
        end
        src_node[1][0] = 0; src_val[1][0] = 100;
        src_node[1][1] = 5; src_val[1][1] = -7;
        src_node[2][0] = 7; src_val[2][0] = 3;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1 chk(done == 1'b0, "R1 done after reset", done, 0);
        push_zero();
        check_vec("R1 zero after reset");

        // Step A: streaming, priority, sums
        clear_step();
        load_basic();
        plan_expect();
        fork drive_grp(0); drive_grp(1); drive_grp(2); join
        for (int k = 0; k < 7; k++)
            chk(acc_cyc[0][k+1] - acc_cyc[0][k] == 1, "R3 back-to-back",
                acc_cyc[0][k+1] - acc_cyc[0][k], 1);
        chk(acc_cyc[0][0] < acc_cyc[1][0], "R6 lowest index first",
            acc_cyc[1][0] - acc_cyc[0][0], 8);
        wait_done();
        check_vec("R2 R8 summed vector");

        // Step B: same-node hazards
        clear_step();
        src_len = '{3, 1, 1};
        src_dly = '{0, 0, 0};
        src_node[0][0] = 3; src_val[0][0] = 5;
        src_node[0][1] = 3; src_val[0][1] = 6;
        src_node[0][2] = 3; src_val[0][2] = -2;
        src_node[1][0] = 4; src_val[1][0] = 9;
        src_node[2][0] = 3; src_val[2][0] = 1;
        plan_expect();
        fork drive_grp(0); drive_grp(1); drive_grp(2); join
        chk(acc_cyc[0][1] - acc_cyc[0][0] == LAT + 1, "R4 lock gap",
            acc_cyc[0][1] - acc_cyc[0][0], LAT + 1);
        chk(acc_cyc[0][2] - acc_cyc[0][1] == LAT + 1, "R4 lock gap second",
            acc_cyc[0][2] - acc_cyc[0][1], LAT + 1);
        chk(acc_cyc[1][0] == acc_cyc[0][0] + 1, "R5 free port proceeds",
            acc_cyc[1][0], acc_cyc[0][0] + 1);
        chk(acc_cyc[2][0] < acc_cyc[0][1], "R5 third port during stall",
            acc_cyc[2][0], acc_cyc[0][1]);
        wait_done();
        check_vec("R4 R2 no lost update");

        // Step C: late group, requests after last and after done
        clear_step();
        src_len = '{1, 1, 2};
        src_dly = '{0, 0, 30};
        src_node[0][0] = 1; src_val[0][0] = 4;
        src_node[1][0] = 1; src_val[1][0] = -20;
        src_node[2][0] = 6; src_val[2][0] = 77;
        src_node[2][1] = 1; src_val[2][1] = 2;
        plan_expect();
        fork
            drive_grp(0); drive_grp(1); drive_grp(2);
            begin
                repeat (6) @(negedge clk);
                in_vld[0] = 1'b1; in_node[0] = 3'd1; in_val[0] = 16'd50; in_last[0] = 1'b0;
                for (int i = 0; i < 15; i++) begin
                    #1 chk(in_rdy[0] == 1'b0, "R9 ready after last", in_rdy[0], 0);
                    @(negedge clk);
                end
                in_vld[0] = 1'b0;
                #1 chk(done == 1'b0, "R7 waits for slow group", done, 0);
            end
        join
        wait_done();
        in_vld[0] = 1'b1; in_node[0] = 3'd1; in_val[0] = 16'd50;
        for (int i = 0; i < 4; i++) begin
            #1 chk(in_rdy[0] == 1'b0, "R9 ready after done", in_rdy[0], 0);
            @(negedge clk);
        end
        in_vld[0] = 1'b0;
        #1 chk(done == 1'b1, "R8 done holds", done, 1);
        check_vec("R9 R8 vector unchanged");

        // Step D: clear, then repeat step A
        clear_step();
        #1 chk(done == 1'b0, "R10 done after clear", done, 0);
        push_zero();
        check_vec("R1 R10 zero after clear");
        load_basic();
        plan_expect();
        fork drive_grp(0); drive_grp(1); drive_grp(2); join
        wait_done();
        check_vec("R10 fresh step");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule